// File: doc/BRIEF.md
# RTC Interrupt Flag and Output Controller

This block keeps the interrupt status of a real-time clock and drives its three active-low interrupt outputs. Two alarm sources are handled: a weekly alarm and a daily alarm. A time comparator outside the block sends a one-cycle match strobe. The block waits a fixed number of ticks of the 32.768 kHz enable, then raises the alarm flag, but only while that alarm's enable input is 1. A periodic source sends a strobe that raises the periodic flag straight away. This is level-mode behaviour: the flag stays set until software clears it.

Software reaches the flags through one 5-bit register. A write with a 0 in a flag position clears that flag. A 1 in a flag position does nothing. Every interrupt pin is low exactly while its flag reads 1. The same register holds two active-low clock-output enable bits. The oscillator signal passes to the clock output unless both of these bits are 1.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, rd_data reads 0, all three interrupt outputs are high, and clk_out follows osc_in because both clock-off bits are 0.
- R2: Register layout is bit 0 periodic flag, bit 1 weekly flag, bit 2 daily flag, bit 3 clock-off A, bit 4 clock-off B. A write loads bits 3 and 4 directly. clk_out is 1 while both clock-off bits are 1; otherwise clk_out equals osc_in.
- R3: A per_strobe sampled at a clock edge sets the periodic flag (rd_data bit 0) after that edge, and irq_per_n is low exactly while that flag is 1.
- R4: A write with bit 0 = 0 clears the periodic flag after the edge, and irq_per_n stays high until the next per_strobe.
- R5: Writing 1 to any flag bit (bits 0 to 2) leaves that flag unchanged.
- R6: After an accepted alarm match, the alarm flag sets at the edge that samples the second tick_32k pulse arriving in a cycle after the match cycle. A match is accepted only while that alarm's enable input is 1.
- R7: A match strobe that arrives while that alarm's delay is already pending is ignored and does not restart the delay.
- R8: A write with an alarm flag bit = 0 clears that flag and drives its pin high. The next accepted match sets the flag again after the delay.
- R9: While an alarm's enable input is 0, its flag reads 0 and its pin is high. A pending delay is discarded and the stored flag is cleared.
- R10: irq_wk_n and irq_dy_n are low exactly while rd_data bit 1 and bit 2 read 1.
- R11: When a set event and a write of 0 to the same flag land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| osc_in | input | 1 | Oscillator clock, treated as data for the clock output |
| wk_match | input | 1 | Weekly alarm match strobe |
| dy_match | input | 1 | Daily alarm match strobe |
| wk_alarm_on | input | 1 | Weekly alarm enable |
| dy_alarm_on | input | 1 | Daily alarm enable |
| per_strobe | input | 1 | Periodic interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write data |
| rd_data | output | 5 | Register read data |
| irq_per_n | output | 1 | Periodic interrupt, active low |
| irq_wk_n | output | 1 | Weekly alarm interrupt, active low |
| irq_dy_n | output | 1 | Daily alarm interrupt, active low |
| clk_out | output | 1 | Gated 32 kHz clock output |

## Verification
The assertions assume that strobes and ticks are sampled synchronously to clk. They also assume that a falling interrupt output can only follow a cycle that had a strobe or a tick. The alarm-enable inputs count as static register bits that change between cycles only. The stimulus drives every input on the falling edge. Ticks, strobes and writes are mostly short random pulses. The enables are held high most of the time and dropped now and then, so the delay, discard and collision paths all get exercised.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_W     = 5;
  localparam int B_PER     = 0;
  localparam int B_WK      = 1;
  localparam int B_DY      = 2;
  localparam int B_CKOFF_A = 3;
  localparam int B_CKOFF_B = 4;
  localparam int N_ALARM   = 2;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_l
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_l = sh_q[STAGES-1];
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag #(
  parameter int DELAY_TICKS = 2
) (
  input  logic clk,
  input  logic rst_l,
  input  logic tick,
  input  logic match,
  input  logic enable,
  input  logic clr_req,
  output logic flag
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          set_ev;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    set_ev = 1'b0;
    if (!enable) begin
      pend_d = 1'b0;
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (pend_q) begin
        if (tick) begin
          if (cnt_q == LAST) begin
            set_ev = 1'b1;
            pend_d = 1'b0;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end else if (match) begin
        pend_d = 1'b1;
        cnt_d  = '0;
      end
      if (set_ev)       flag_d = 1'b1;
      else if (clr_req) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q & enable;
endmodule

// File: rtl/rtc_per_flag.sv
module rtc_per_flag (
  input  logic clk,
  input  logic rst_l,
  input  logic strobe,
  input  logic clr_req,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (strobe)       flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rtc_clk_gate.sv
module rtc_clk_gate (
  input  logic clk,
  input  logic rst_l,
  input  logic load,
  input  logic off_a_in,
  input  logic off_b_in,
  input  logic osc_in,
  output logic off_a,
  output logic off_b,
  output logic clk_out
);
  logic a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = off_a_in;
    b_d = off_b_in;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (load) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign off_a   = a_q;
  assign off_b   = b_q;
  assign clk_out = (a_q & b_q) | osc_in;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DELAY_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_32k,
  input  logic             osc_in,
  input  logic             wk_match,
  input  logic             dy_match,
  input  logic             wk_alarm_on,
  input  logic             dy_alarm_on,
  input  logic             per_strobe,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_per_n,
  output logic             irq_wk_n,
  output logic             irq_dy_n,
  output logic             clk_out
);
  logic               rst_l;
  logic [N_ALARM-1:0] al_match, al_en, al_clr, al_flag;
  logic               per_flag, off_a, off_b;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_l(rst_l)
  );

  assign al_match = {dy_match, wk_match};
  assign al_en    = {dy_alarm_on, wk_alarm_on};

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
    assign al_clr[i] = wr_en & ~wr_data[B_WK + i];
    rtc_alarm_flag #(.DELAY_TICKS(DELAY_TICKS)) u_flag (
      .clk(clk), .rst_l(rst_l), .tick(tick_32k), .match(al_match[i]),
      .enable(al_en[i]), .clr_req(al_clr[i]), .flag(al_flag[i])
    );
  end

  rtc_per_flag u_per (
    .clk(clk), .rst_l(rst_l), .strobe(per_strobe),
    .clr_req(wr_en & ~wr_data[B_PER]), .flag(per_flag)
  );

  rtc_clk_gate u_ck (
    .clk(clk), .rst_l(rst_l), .load(wr_en),
    .off_a_in(wr_data[B_CKOFF_A]), .off_b_in(wr_data[B_CKOFF_B]),
    .osc_in(osc_in), .off_a(off_a), .off_b(off_b), .clk_out(clk_out)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[B_PER]     = per_flag;
    rd_data[B_WK]      = al_flag[0];
    rd_data[B_DY]      = al_flag[1];
    rd_data[B_CKOFF_A] = off_a;
    rd_data[B_CKOFF_B] = off_b;
  end

  assign irq_per_n = ~per_flag;
  assign irq_wk_n  = ~al_flag[0];
  assign irq_dy_n  = ~al_flag[1];
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_32k,
  input logic       wk_alarm_on,
  input logic       dy_alarm_on,
  input logic       per_strobe,
  input logic       wr_en,
  input logic [4:0] wr_data,
  input logic [4:0] rd_data,
  input logic       irq_per_n,
  input logic       irq_wk_n,
  input logic       irq_dy_n,
  input logic       clk_out
);
  // R3
  per_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_strobe |=> (!irq_per_n && rd_data[0]));

  // R4
  per_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && !per_strobe) |=> irq_per_n);

  // R3
  per_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_per_n) |-> $past(per_strobe));

  // R2
  ckoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && rd_data[4]) |-> clk_out);

  // R6
  wk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_wk_n) |-> $past(tick_32k && wk_alarm_on));

  // R6
  dy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_dy_n) |-> $past(tick_32k && dy_alarm_on));

  // R9
  wk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wk_alarm_on |-> (irq_wk_n && !rd_data[1]));

  // R9
  dy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dy_alarm_on |-> (irq_dy_n && !rd_data[2]));

  // R11
  per_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_strobe && wr_en && !wr_data[0]) |=> !irq_per_n);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
  .wk_alarm_on(wk_alarm_on), .dy_alarm_on(dy_alarm_on),
  .per_strobe(per_strobe), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_per_n(irq_per_n), .irq_wk_n(irq_wk_n),
  .irq_dy_n(irq_dy_n), .clk_out(clk_out)
);

// File: tb/sim_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0, osc_in = 1'b0;
  logic       wk_match = 1'b0, dy_match = 1'b0;
  logic       wk_alarm_on = 1'b1, dy_alarm_on = 1'b1;
  logic       per_strobe = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_data = 5'h1f;
  logic [4:0] rd_data;
  logic       irq_per_n, irq_wk_n, irq_dy_n, clk_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  logic       e_per, e_offa, e_offb;
  logic [1:0] e_flag, e_pend;
  int         e_cnt [2];

  always #4 clk = ~clk;

  rtc_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .osc_in(osc_in),
    .wk_match(wk_match), .dy_match(dy_match),
    .wk_alarm_on(wk_alarm_on), .dy_alarm_on(dy_alarm_on),
    .per_strobe(per_strobe), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_per_n(irq_per_n), .irq_wk_n(irq_wk_n),
    .irq_dy_n(irq_dy_n), .clk_out(clk_out)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_clk(input logic a, input logic b, input logic o);
    return (a && b) ? 1'b1 : o;
  endfunction

  function automatic logic [4:0] exp_rd();
    logic [1:0] en;
    en = {dy_alarm_on, wk_alarm_on};
    return {e_offb, e_offa, e_flag[1] & en[1], e_flag[0] & en[0], e_per};
  endfunction

  task automatic compare();
    logic [4:0] r;
    r = exp_rd();
    chk(rd_data[0], r[0], "R3 R4 R5 R11 periodic flag");
    chk(rd_data[2:1], r[2:1], "R6 R7 R8 R9 alarm flags");
    chk(rd_data[4:3], r[4:3], "R2 clock-off bits");
    chk(irq_per_n, !r[0], "R3 periodic pin");
    chk({irq_dy_n, irq_wk_n}, {!r[2], !r[1]}, "R10 alarm pins");
    chk(clk_out, exp_clk(r[3], r[4], osc_in), "R2 clk_out");
  endtask

  task automatic model_reset();
    e_per = 0; e_offa = 0; e_offb = 0; e_flag = 0; e_pend = 0;
    e_cnt[0] = 0; e_cnt[1] = 0;
  endtask

  // drive one cycle of inputs at negedge, advance model, sample at next negedge
  task automatic step(input logic t, input logic wm, input logic dm, input logic ps,
                      input logic we, input logic [4:0] wd, input logic osc);
    logic [1:0] m, en, setv;
    tick_32k = t; wk_match = wm; dy_match = dm; per_strobe = ps;
    wr_en = we; wr_data = wd; osc_in = osc;
    m = {dm, wm};
    en = {dy_alarm_on, wk_alarm_on};
    for (int i = 0; i < 2; i++) begin
      setv[i] = 1'b0;
      if (!en[i]) begin
        e_flag[i] = 0; e_pend[i] = 0; e_cnt[i] = 0;
      end else begin
        if (e_pend[i]) begin
          if (t) begin
            if (e_cnt[i] == 1) begin setv[i] = 1; e_pend[i] = 0; e_cnt[i] = 0; end
            else e_cnt[i] = e_cnt[i] + 1;
          end
        end else if (m[i]) begin
          e_pend[i] = 1; e_cnt[i] = 0;
        end
        if (setv[i]) e_flag[i] = 1;
        else if (we && !wd[1+i]) e_flag[i] = 0;
      end
    end
    if (ps) e_per = 1;
    else if (we && !wd[0]) e_per = 0;
    if (we) begin e_offa = wd[3]; e_offb = wd[4]; end
    @(posedge clk);
    @(negedge clk);
    compare();
    tick_32k = 0; wk_match = 0; dy_match = 0; per_strobe = 0; wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 5'h1f, osc_in);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    chk(rd_data, 0, "R1 rd_data in reset");
    chk({irq_per_n, irq_wk_n, irq_dy_n}, 3'b111, "R1 pins in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    osc_in = 1'b1; #1;
    chk(clk_out, 1, "R1 clk_out follows osc high");
    osc_in = 1'b0; #1;
    chk(clk_out, 0, "R1 clk_out follows osc low");
    chk(rd_data, 0, "R1 rd_data after reset");

    // R2: clock gating by both bits
    step(0, 0, 0, 0, 1, 5'b01111, 1'b0);
    chk(clk_out, 0, "R2 one off bit only");
    step(0, 0, 0, 0, 1, 5'b11111, 1'b0);
    chk(clk_out, 1, "R2 both off bits");
    step(0, 0, 0, 0, 1, 5'b00111, 1'b0);

    // R3, R4, R5 periodic
    step(0, 0, 0, 1, 0, 5'h1f, 0);
    chk(irq_per_n, 0, "R3 strobe drives pin low");
    step(0, 0, 0, 0, 1, 5'b00111, 0);
    chk(rd_data[0], 1, "R5 write 1 keeps periodic flag");
    step(0, 0, 0, 0, 1, 5'b00110, 0);
    chk(irq_per_n, 1, "R4 write 0 releases pin");
    idle(3);
    chk(irq_per_n, 1, "R4 pin stays high until next strobe");
    // R11 collision
    step(0, 0, 0, 1, 1, 5'b00110, 0);
    chk(rd_data[0], 1, "R11 set beats clear");

    // R6 weekly delay
    step(0, 1, 0, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    chk(irq_wk_n, 1, "R6 still high after first tick");
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    chk(irq_wk_n, 0, "R6 low after second tick");
    // R8 clear and re-arm
    step(0, 0, 0, 0, 1, 5'b00101, 0);
    chk(irq_wk_n, 1, "R8 clear releases pin");
    // R7: second match during delay ignored
    step(0, 1, 0, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    step(0, 1, 0, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    chk(irq_wk_n, 0, "R7 R8 delay not restarted");
    // R11 alarm collision on daily
    step(0, 0, 1, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 1, 5'b00011, 0);
    chk(irq_dy_n, 0, "R11 alarm set beats clear");
    // R9 disable
    dy_alarm_on = 1'b0;
    step(0, 0, 0, 0, 0, 5'h1f, 0);
    chk(rd_data[2], 0, "R9 disabled flag reads 0");
    step(0, 0, 1, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    step(1, 0, 0, 0, 0, 5'h1f, 0);
    chk(irq_dy_n, 1, "R9 match ignored while disabled");
    dy_alarm_on = 1'b1;
    idle(2);
    chk(rd_data[2], 0, "R9 stored flag was cleared");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic t, wm, dm, ps, we;
      if ($urandom_range(0, 49) == 0) wk_alarm_on = ~wk_alarm_on;
      if ($urandom_range(0, 49) == 0) dy_alarm_on = ~dy_alarm_on;
      if (!wk_alarm_on && $urandom_range(0, 3) == 0) wk_alarm_on = 1'b1;
      if (!dy_alarm_on && $urandom_range(0, 3) == 0) dy_alarm_on = 1'b1;
      t  = ($urandom_range(0, 3) == 0);
      wm = ($urandom_range(0, 15) == 0);
      dm = ($urandom_range(0, 15) == 0);
      ps = ($urandom_range(0, 29) == 0);
      we = ($urandom_range(0, 9) == 0);
      step(t, wm, dm, ps, we, 5'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule